// File: doc/BRIEF.md
# Receive Packet FIFO with Per-Packet Status

This block sits between a receive MAC and a host that drains frames by programmed reads. Bytes arrive one per cycle from the MAC side, marked with start and end flags and, on the last byte, a 4-bit error code. The block stores the bytes in a circular byte store. It also keeps a small queue of descriptors, one for each completed packet, so that the host always sees the length and error code of the oldest packet through a single 16-bit status word.

The host pulls data as little-endian 16-bit words from the oldest packet. Each word read lowers the remaining byte count shown in the status word. When the host has finished with a packet, or does not want it, it issues a discard command, and the next packet becomes the oldest. Four diagnostic flags report the following: a packet is being received, storage has overflowed, the descriptor queue is full, and the host has read past the end of a packet. The last of these also raises adapter failure until the receive path is reset.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, host_status reads 16'h8000, host_word reads 0, and diag_flags, adapter_fail and rx_complete are all 0.
- R2: While at least one complete packet is held, host_status has bit 15 = 0, bits 14..11 = that packet's error code and bits 10..0 = its unread byte count. With no complete packet held, bit 15 = 1, bits 14..11 = 0 and bits 10..0 = the number of bytes taken so far of the packet being received (0 if none).
- R3: host_word holds the next unread byte of the oldest packet in bits 7..0 and the byte after it in bits 15..8. When only one byte remains, bits 15..8 are zero. A read (host_rd) consumes two bytes, or one for the odd last byte, and lowers the count by that amount.
- R4: The command with opcode 8 (cmd_valid with cmd_op = 8) drops the unread remainder and the descriptor of the oldest packet, and has no effect when no packet is held. Opcodes other than 5 and 8 have no effect.
- R5: At most SLOTS (8) complete packets are held. While that many are held, diag_flags[2] is 1 and a new packet is dropped without a trace. The flag returns to 0 as soon as a packet is discarded.
- R6: A byte that arrives with the byte store full aborts its packet. The packet's stored bytes are removed, a descriptor with code 4'b1000 and count 0 is queued, and diag_flags[1] is set. While diag_flags[1] is set, each newly started packet is refused and recorded the same way. The flag clears once the host has removed OVR_HYST (4) bytes by reads or discards.
- R7: A read with no complete packet held, or with the oldest packet's count at 0, sets diag_flags[3] and adapter_fail and moves no data. Both stay set until opcode 5 or rst_n.
- R8: diag_flags[0] is 1 from the cycle after an accepted start byte until the cycle after the end byte.
- R9: rx_complete is high for exactly the one cycle after a descriptor is queued.
- R10: Bytes beyond MAX_LEN (1514) in one packet are not stored. The packet is queued with count 1514 and code 4'b1001.
- R11: A read and a discard in the same cycle act as a discard alone: no bytes are read and no underrun is raised. A packet completing in the same cycle as a discard is queued normally.
- R12: Opcode 5 empties the byte store and the descriptor queue, abandons a packet in progress and clears all flags. Bytes arriving afterwards without a start flag are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_valid | input | 1 | A MAC byte is present this cycle |
| mac_data | input | 8 | MAC byte |
| mac_sop | input | 1 | First byte of a packet |
| mac_eop | input | 1 | Last byte of a packet |
| mac_err | input | 4 | Error code of the packet, sampled with mac_eop |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 5 | Command opcode (5 reset receive path, 8 discard oldest) |
| host_rd | input | 1 | Consume the word on host_word |
| host_word | output | 16 | Next data word of the oldest packet |
| host_status | output | 16 | Status word of the oldest packet |
| diag_flags | output | 4 | {underrun, queue full, overrun, receiving} |
| adapter_fail | output | 1 | Hard failure after a read past a packet end |
| rx_complete | output | 1 | One-cycle pulse after a descriptor is queued |

## Verification
Two collisions are provoked on purpose. In the first, the host strobes a read and a discard in the same cycle on a four-byte packet. The result is judged by the status returning to empty with the underrun flag still clear. In the second, the discard command is raised on the exact cycle that carries the end byte of a second packet. The bench then checks that the first packet is gone, that the second one is reported with its own count and readable data, and that rx_complete still pulsed.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int LEN_W = 11;

  localparam logic [3:0] CODE_OVERRUN  = 4'b1000;
  localparam logic [3:0] CODE_OVERSIZE = 4'b1001;

  localparam logic [4:0] OP_RX_RESET = 5'd5;
  localparam logic [4:0] OP_DISCARD  = 5'd8;

  typedef struct packed {
    logic [3:0]       code;
    logic [LEN_W-1:0] len;
  } desc_t;

  typedef enum logic [1:0] {
    ING_IDLE = 2'd0,
    ING_RECV = 2'd1,
    ING_DROP = 2'd2
  } ing_state_e;

  // bytes one host word takes out of a packet with rem bytes left
  function automatic logic [1:0] word_take(input logic [LEN_W-1:0] rem);
    if (rem >= LEN_W'(2)) return 2'd2;
    else if (rem == LEN_W'(1)) return 2'd1;
    else return 2'd0;
  endfunction

  function automatic logic [15:0] pack_status(input logic have, input desc_t d,
                                              input logic [LEN_W-1:0] partial);
    if (have) return {1'b0, d.code, d.len};
    else return {1'b1, 4'b0000, partial};
  endfunction

endpackage

// File: rtl/rxq_byte_store.sv
module rxq_byte_store import rxq_pkg::*; #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             rewind_en,
  input  logic [PW-1:0]    rewind_ptr,
  input  logic [LEN_W-1:0] adv_amt,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    free_cnt,
  output logic [7:0]       rd_lo,
  output logic [7:0]       rd_hi
);

  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, rd_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (clr) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (rewind_en) wr_q <= rewind_ptr;
      else if (wr_en) wr_q <= wr_q + PW'(1);
      rd_q <= rd_q + PW'(adv_amt);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_q[AW-1:0]] <= wr_byte;
  end

  assign rd_nxt   = rd_q + PW'(1);
  assign rd_lo    = mem[rd_q[AW-1:0]];
  assign rd_hi    = mem[rd_nxt[AW-1:0]];
  assign wr_ptr   = wr_q;
  assign free_cnt = DEPTH_V - (wr_q - rd_q);

  // a byte is never stored into a full store
  assert_no_write_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> free_cnt != '0);
  assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= DEPTH_V);

endmodule

// File: rtl/rxq_desc_queue.sv
module rxq_desc_queue import rxq_pkg::*; #(
  parameter int SLOTS = 8,
  localparam int IW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_en,
  input  desc_t         push_desc,
  input  logic          pop_en,
  input  logic          dec_en,
  input  logic [1:0]    dec_amt,
  output desc_t         head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  desc_t         slots [SLOTS];
  logic [IW-1:0] rd_idx, wr_idx;
  logic [CW-1:0] cnt_q;
  logic          pop_eff, dec_eff;

  assign empty   = cnt_q == '0;
  assign full    = cnt_q == CW'(SLOTS);
  assign pop_eff = pop_en && !empty;
  assign dec_eff = dec_en && !empty && !pop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      wr_idx <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      rd_idx <= '0;
      wr_idx <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_en) wr_idx <= wr_idx + IW'(1);
      if (pop_eff) rd_idx <= rd_idx + IW'(1);
      cnt_q <= cnt_q + CW'(push_en) - CW'(pop_eff);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push_en) slots[wr_idx] <= push_desc;
      if (dec_eff) slots[rd_idx].len <= slots[rd_idx].len - LEN_W'(dec_amt);
    end
  end

  assign head  = slots[rd_idx];
  assign count = cnt_q;

  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SLOTS));
  assert_no_dec_below_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_eff |-> head.len >= LEN_W'(dec_amt));

endmodule

// File: rtl/rxq_ingress.sv
module rxq_ingress import rxq_pkg::*; #(
  parameter int DEPTH   = 2048,
  parameter int MAX_LEN = 1514,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mac_valid,
  input  logic [7:0]       mac_data,
  input  logic             mac_sop,
  input  logic             mac_eop,
  input  logic [3:0]       mac_err,
  input  logic [PW-1:0]    free_cnt,
  input  logic [PW-1:0]    wr_ptr,
  input  logic             q_full,
  input  logic             ovr_active,
  output logic             wr_en,
  output logic [7:0]       wr_byte,
  output logic             rewind_en,
  output logic [PW-1:0]    rewind_ptr,
  output logic             push_en,
  output desc_t            push_desc,
  output logic             ovr_event,
  output logic             receiving,
  output logic [LEN_W-1:0] cur_len
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

  ing_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             big_q, big_d;
  logic [PW-1:0]    start_q, start_d;
  logic             at_cap, store_full;

  assign at_cap     = len_q == CAP;
  assign store_full = free_cnt == '0;

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    big_d     = big_q;
    start_d   = start_q;
    wr_en     = 1'b0;
    rewind_en = 1'b0;
    push_en   = 1'b0;
    push_desc = '0;
    ovr_event = 1'b0;
    if (mac_valid) begin
      unique case (state_q)
        ING_IDLE: begin
          if (mac_sop) begin
            if (q_full) begin
              if (!mac_eop) state_d = ING_DROP;
            end else if (ovr_active || store_full) begin
              push_en   = 1'b1;
              push_desc = '{code: CODE_OVERRUN, len: '0};
              ovr_event = store_full;
              if (!mac_eop) state_d = ING_DROP;
            end else begin
              wr_en   = 1'b1;
              start_d = wr_ptr;
              big_d   = 1'b0;
              if (mac_eop) begin
                push_en   = 1'b1;
                push_desc = '{code: mac_err, len: LEN_W'(1)};
                len_d     = '0;
              end else begin
                len_d   = LEN_W'(1);
                state_d = ING_RECV;
              end
            end
          end
        end
        ING_RECV: begin
          if (!at_cap && store_full) begin
            rewind_en = 1'b1;
            push_en   = 1'b1;
            push_desc = '{code: CODE_OVERRUN, len: '0};
            ovr_event = 1'b1;
            len_d     = '0;
            state_d   = mac_eop ? ING_IDLE : ING_DROP;
          end else begin
            if (at_cap) big_d = 1'b1;
            else begin
              wr_en = 1'b1;
              len_d = len_q + LEN_W'(1);
            end
            if (mac_eop) begin
              push_en        = 1'b1;
              push_desc.len  = at_cap ? len_q : len_q + LEN_W'(1);
              push_desc.code = (at_cap || big_q) ? CODE_OVERSIZE : mac_err;
              len_d          = '0;
              state_d        = ING_IDLE;
            end
          end
        end
        ING_DROP: begin
          if (mac_eop) state_d = ING_IDLE;
        end
        default: state_d = ING_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ING_IDLE;
      len_q   <= '0;
      big_q   <= 1'b0;
      start_q <= '0;
    end else if (clr) begin
      state_q <= ING_IDLE;
      len_q   <= '0;
      big_q   <= 1'b0;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      big_q   <= big_d;
      start_q <= start_d;
    end
  end

  assign wr_byte    = mac_data;
  assign rewind_ptr = start_q;
  assign receiving  = state_q == ING_RECV;
  assign cur_len    = len_q;

  // a packet in flight always has a descriptor slot waiting for it
  assert_recv_has_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    receiving |-> !q_full);
  assert_len_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len <= CAP);
  assert_rewind_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_en |-> !wr_en);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo import rxq_pkg::*; #(
  parameter int DEPTH    = 2048,
  parameter int SLOTS    = 8,
  parameter int MAX_LEN  = 1514,
  parameter int OVR_HYST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mac_valid,
  input  logic [7:0]  mac_data,
  input  logic        mac_sop,
  input  logic        mac_eop,
  input  logic [3:0]  mac_err,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  input  logic        host_rd,
  output logic [15:0] host_word,
  output logic [15:0] host_status,
  output logic [3:0]  diag_flags,
  output logic        adapter_fail,
  output logic        rx_complete
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(SLOTS + 1);

  // named internal events
  logic             cmd_discard, cmd_rx_reset;
  logic             rd_ok, rd_bad;
  logic             have_pkt;
  logic [1:0]       take;
  logic [LEN_W-1:0] rem, adv_amt;

  logic             wr_en, rewind_en, push_en, ovr_event, receiving;
  logic [7:0]       wr_byte, rd_lo, rd_hi;
  logic [PW-1:0]    wr_ptr, free_cnt, rewind_ptr;
  logic [LEN_W-1:0] cur_len;
  desc_t            push_desc, head;
  logic [CW-1:0]    q_count;
  logic             q_empty, q_full;

  logic             underrun_q, ovr_q, done_q;
  logic [LEN_W:0]   removed_q, removed_sum;

  assign cmd_discard  = cmd_valid && (cmd_op == OP_DISCARD);
  assign cmd_rx_reset = cmd_valid && (cmd_op == OP_RX_RESET);

  assign have_pkt = !q_empty;
  assign rem      = have_pkt ? head.len : '0;
  assign take     = word_take(rem);
  assign rd_ok    = host_rd && !cmd_discard && (take != 2'd0);
  assign rd_bad   = host_rd && !cmd_discard && (take == 2'd0);
  assign adv_amt  = cmd_discard ? rem : (rd_ok ? LEN_W'(take) : '0);

  rxq_byte_store #(.DEPTH(DEPTH)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cmd_rx_reset),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .rewind_en  (rewind_en),
    .rewind_ptr (rewind_ptr),
    .adv_amt    (adv_amt),
    .wr_ptr     (wr_ptr),
    .free_cnt   (free_cnt),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi)
  );

  rxq_desc_queue #(.SLOTS(SLOTS)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_rx_reset),
    .push_en   (push_en),
    .push_desc (push_desc),
    .pop_en    (cmd_discard),
    .dec_en    (rd_ok),
    .dec_amt   (take),
    .head      (head),
    .count     (q_count),
    .empty     (q_empty),
    .full      (q_full)
  );

  rxq_ingress #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) ingress_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cmd_rx_reset),
    .mac_valid  (mac_valid),
    .mac_data   (mac_data),
    .mac_sop    (mac_sop),
    .mac_eop    (mac_eop),
    .mac_err    (mac_err),
    .free_cnt   (free_cnt),
    .wr_ptr     (wr_ptr),
    .q_full     (q_full),
    .ovr_active (ovr_q),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .rewind_en  (rewind_en),
    .rewind_ptr (rewind_ptr),
    .push_en    (push_en),
    .push_desc  (push_desc),
    .ovr_event  (ovr_event),
    .receiving  (receiving),
    .cur_len    (cur_len)
  );

  assign removed_sum = removed_q + {1'b0, adv_amt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun_q <= 1'b0;
      ovr_q      <= 1'b0;
      removed_q  <= '0;
      done_q     <= 1'b0;
    end else if (cmd_rx_reset) begin
      underrun_q <= 1'b0;
      ovr_q      <= 1'b0;
      removed_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= push_en;
      if (rd_bad) underrun_q <= 1'b1;
      if (ovr_event) begin
        ovr_q     <= 1'b1;
        removed_q <= '0;
      end else if (ovr_q) begin
        if (removed_sum >= (LEN_W + 1)'(OVR_HYST)) begin
          ovr_q     <= 1'b0;
          removed_q <= '0;
        end else begin
          removed_q <= removed_sum;
        end
      end
    end
  end

  assign host_word    = (take == 2'd0) ? 16'h0000
                      : {(take == 2'd2) ? rd_hi : 8'h00, rd_lo};
  assign host_status  = pack_status(have_pkt, head, cur_len);
  assign diag_flags   = {underrun_q, q_full, ovr_q, receiving};
  assign adapter_fail = underrun_q;
  assign rx_complete  = done_q;

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_q && !cmd_rx_reset) |=> underrun_q);
  assert_complete_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |-> !host_status[15]);
  assert_ovr_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_event && !cmd_rx_reset) |=> diag_flags[1]);
  assert_discard_masks_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && cmd_discard && !underrun_q && !cmd_rx_reset) |=> !adapter_fail);
  assert_read_lowers_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !cmd_rx_reset) |=> host_status[10:0] == $past(rem) - LEN_W'($past(take)));

endmodule

// File: tb/rxq_fifo_tb_top.sv
module rxq_fifo_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mac_valid = 1'b0, mac_sop = 1'b0, mac_eop = 1'b0;
  logic [7:0]  mac_data = '0;
  logic [3:0]  mac_err = '0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_op = '0;
  logic        host_rd = 1'b0;
  logic [15:0] host_word, host_status;
  logic [3:0]  diag_flags;
  logic        adapter_fail, rx_complete;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxq_fifo dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mac_valid    (mac_valid),
    .mac_data     (mac_data),
    .mac_sop      (mac_sop),
    .mac_eop      (mac_eop),
    .mac_err      (mac_err),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .host_rd      (host_rd),
    .host_word    (host_word),
    .host_status  (host_status),
    .diag_flags   (diag_flags),
    .adapter_fail (adapter_fail),
    .rx_complete  (rx_complete)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic send_bytes(input int n, input logic [7:0] base, input bit with_sop,
                            input bit with_eop, input logic [3:0] err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mac_valid = 1'b1;
      mac_data  = base + 8'(i);
      mac_sop   = with_sop && (i == 0);
      mac_eop   = with_eop && (i == n - 1);
      mac_err   = err;
    end
    @(negedge clk);
    mac_valid = 1'b0;
    mac_sop   = 1'b0;
    mac_eop   = 1'b0;
  endtask

  task automatic command(input logic [4:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic host_read(output logic [15:0] w);
    @(negedge clk);
    w       = host_word;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 status after reset", 32'(host_status), 32'h8000);
    check("R1 word after reset", 32'(host_word), 32'h0);
    check("R1 flags after reset", 32'({diag_flags, adapter_fail, rx_complete}), 32'h0);
  endtask

  task automatic t_basic_read();
    logic [15:0] w;
    send_bytes(5, 8'h10, 1, 1, 4'h0);
    check("R9 rx_complete pulse", 32'(rx_complete), 32'h1);
    check("R2 status of 5-byte packet", 32'(host_status), 32'h0005);
    @(negedge clk);
    check("R9 rx_complete one cycle", 32'(rx_complete), 32'h0);
    host_read(w);
    check("R3 first word", 32'(w), 32'h1110);
    check("R3 count after first read", 32'(host_status), 32'h0003);
    host_read(w);
    check("R3 second word", 32'(w), 32'h1312);
    host_read(w);
    check("R3 odd last byte padded", 32'(w), 32'h0014);
    check("R3 count at end", 32'(host_status), 32'h0000);
    host_read(w);
    check("R7 underrun flag", 32'(diag_flags[3]), 32'h1);
    check("R7 adapter_fail", 32'(adapter_fail), 32'h1);
    check("R7 no data moved", 32'(host_status), 32'h0000);
    command(5'd3);
    check("R4 other opcode keeps failure", 32'(adapter_fail), 32'h1);
    check("R4 other opcode keeps packet", 32'(host_status), 32'h0000);
    command(5'd5);
    check("R7 rx reset clears failure", 32'(adapter_fail), 32'h0);
    check("R12 rx reset empties queue", 32'(host_status), 32'h8000);
  endtask

  task automatic t_error_discard();
    send_bytes(3, 8'h20, 1, 1, 4'b1101);
    check("R2 error code in status", 32'(host_status), 32'h6803);
    send_bytes(2, 8'h30, 1, 1, 4'b0010);
    check("R2 oldest stays at head", 32'(host_status), 32'h6803);
    command(5'd8);
    check("R4 discard advances", 32'(host_status), 32'h1002);
    command(5'd8);
    check("R4 discard to empty", 32'(host_status), 32'h8000);
    command(5'd8);
    check("R4 discard on empty", 32'(host_status), 32'h8000);
    check("R4 discard on empty flags", 32'(diag_flags), 32'h0);
  endtask

  task automatic t_in_progress();
    logic [15:0] w;
    send_bytes(2, 8'h40, 1, 0, 4'h0);
    check("R8 receiving during packet", 32'(diag_flags[0]), 32'h1);
    check("R2 partial count", 32'(host_status), 32'h8002);
    send_bytes(1, 8'h42, 0, 1, 4'h0);
    check("R8 receiving ends", 32'(diag_flags[0]), 32'h0);
    check("R2 completed count", 32'(host_status), 32'h0003);
    host_read(w);
    check("R3 word of joined packet", 32'(w), 32'h4140);
    command(5'd8);
  endtask

  task automatic t_slot_limit();
    for (int i = 0; i < 8; i++) send_bytes(2, 8'(2 * i), 1, 1, 4'h0);
    check("R5 queue full flag", 32'(diag_flags[2]), 32'h1);
    send_bytes(2, 8'hE0, 1, 1, 4'h0);
    check("R5 ninth packet no completion", 32'(rx_complete), 32'h0);
    check("R5 ninth packet not receiving", 32'(diag_flags[0]), 32'h0);
    command(5'd8);
    check("R5 flag clears after discard", 32'(diag_flags[2]), 32'h0);
    for (int i = 0; i < 7; i++) begin
      check("R5 held packet", 32'(host_status), 32'h0002);
      command(5'd8);
    end
    check("R5 ninth packet was dropped", 32'(host_status), 32'h8000);
  endtask

  task automatic t_oversize();
    logic [15:0] w;
    send_bytes(1520, 8'h00, 1, 1, 4'h0);
    check("R10 oversize status", 32'(host_status), 32'h4DEA);
    host_read(w);
    check("R10 oversize data start", 32'(w), 32'h0100);
    command(5'd8);
    check("R10 discard oversize", 32'(host_status), 32'h8000);
    send_bytes(2, 8'hA0, 1, 1, 4'h0);
    host_read(w);
    check("R10 next packet aligned", 32'(w), 32'hA1A0);
    command(5'd8);
  endtask

  task automatic t_overrun();
    logic [15:0] w;
    command(5'd5);
    send_bytes(1000, 8'h00, 1, 1, 4'h0);
    send_bytes(1000, 8'h55, 1, 1, 4'h0);
    check("R6 no overrun yet", 32'(diag_flags[1]), 32'h0);
    send_bytes(100, 8'h77, 1, 1, 4'h0);
    check("R6 overrun flag set", 32'(diag_flags[1]), 32'h1);
    check("R6 aborted packet not receiving", 32'(diag_flags[0]), 32'h0);
    send_bytes(10, 8'h88, 1, 1, 4'h0);
    check("R6 flag holds while refusing", 32'(diag_flags[1]), 32'h1);
    check("R6 first packet intact", 32'(host_status), 32'h03E8);
    host_read(w);
    check("R6 first packet data", 32'(w), 32'h0100);
    check("R6 flag after 2 bytes", 32'(diag_flags[1]), 32'h1);
    host_read(w);
    check("R6 flag clears after 4 bytes", 32'(diag_flags[1]), 32'h0);
    command(5'd8);
    check("R6 second packet intact", 32'(host_status), 32'h03E8);
    host_read(w);
    check("R6 second packet data", 32'(w), 32'h5655);
    command(5'd8);
    check("R6 aborted packet record", 32'(host_status), 32'h4000);
    command(5'd8);
    check("R6 refused packet record", 32'(host_status), 32'h4000);
    command(5'd8);
    check("R6 nothing else held", 32'(host_status), 32'h8000);
  endtask

  task automatic t_collisions();
    logic [15:0] w;
    command(5'd5);
    send_bytes(4, 8'h20, 1, 1, 4'h0);
    @(negedge clk);
    host_rd   = 1'b1;
    cmd_valid = 1'b1;
    cmd_op    = 5'd8;
    @(negedge clk);
    host_rd   = 1'b0;
    cmd_valid = 1'b0;
    check("R11 read+discard empties", 32'(host_status), 32'h8000);
    check("R11 read+discard no underrun", 32'(adapter_fail), 32'h0);
    send_bytes(2, 8'h30, 1, 1, 4'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      mac_valid = 1'b1;
      mac_data  = 8'h60 + 8'(i);
      mac_sop   = (i == 0);
      mac_eop   = (i == 2);
      mac_err   = 4'h0;
      cmd_valid = (i == 2);
      cmd_op    = 5'd8;
    end
    @(negedge clk);
    mac_valid = 1'b0;
    mac_sop   = 1'b0;
    mac_eop   = 1'b0;
    cmd_valid = 1'b0;
    check("R11 completion with discard pulses", 32'(rx_complete), 32'h1);
    check("R11 new packet at head", 32'(host_status), 32'h0003);
    host_read(w);
    check("R11 new packet data", 32'(w), 32'h6160);
    command(5'd8);
    check("R11 only one left", 32'(host_status), 32'h8000);
  endtask

  task automatic t_reset_midpacket();
    logic [15:0] w;
    send_bytes(3, 8'h50, 1, 0, 4'h0);
    command(5'd5);
    check("R12 reset stops receiving", 32'(diag_flags[0]), 32'h0);
    check("R12 reset status empty", 32'(host_status), 32'h8000);
    send_bytes(2, 8'h53, 0, 1, 4'h0);
    check("R12 tail bytes ignored", 32'(host_status), 32'h8000);
    check("R12 tail no completion", 32'(rx_complete), 32'h0);
    send_bytes(1, 8'h99, 1, 1, 4'h0);
    check("R12 fresh packet after reset", 32'(host_status), 32'h0001);
    host_read(w);
    check("R12 fresh packet data", 32'(w), 32'h0099);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_basic_read();
    t_error_discard();
    t_in_progress();
    t_slot_limit();
    t_oversize();
    t_overrun();
    t_collisions();
    t_reset_midpacket();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule